// File: doc/BRIEF.md
# PS/2 Keyboard Scan-Code Decoder

This block listens to a PS/2 keyboard on its two-wire clock and data bus and turns the byte stream into key events. Both bus lines are oversampled by a fast system clock through synchronizer chains. Bits are taken on each falling edge of the synchronized keyboard clock. Every 11-bit frame has its parity and framing checked. Frames that pass are decoded into bytes. A frame that fails is dropped and reported as an error pulse.

Prefix bytes are never passed on as bytes. A release prefix and an extended-key prefix are remembered, then merged into the event for the next ordinary code. Each event is a single-cycle strobe that carries the 8-bit code, an extended flag and a release flag. A bit-level watchdog drops a half-received frame when the keyboard clock stops for too long, so the receiver falls back into step with the next frame. The bus is treated as input only. Commands from host to keyboard and translation to characters are not part of this block.

Top module: `ps2kbd_decoder`

## Requirements
- R1: A frame is 11 bits taken in this order: a start bit of 0, eight data bits with the least significant bit first, a parity bit that makes the count of ones over the data and parity bits odd, and a stop bit of 1. A frame that passes these checks and carries an ordinary code produces an event whose code equals the data byte.
- R2: Bits are taken on falling edges of the keyboard clock after synchronization. The event strobe or error pulse for a frame is high in the third rising system-clock edge after the keyboard clock falls for the stop bit, and is not high after the second.
- R3: An ordinary code byte that arrives with no pending prefix produces an event with the extended flag at 0 and the release flag at 0.
- R4: The byte 0xF0 produces no event and sets the release flag of the next event.
- R5: The byte 0xE0 produces no event and sets the extended flag of the next event. The sequence E0, F0, code produces one event with both flags at 1.
- R6: A code that is received again and again produces one event per frame, with no suppression of repeats.
- R7: A frame with bad parity produces a one-cycle error pulse and no event, and it clears any pending prefix.
- R8: A frame whose stop bit is 0 is handled the same way as a parity error.
- R9: If the keyboard clock shows no falling edge for TIMEOUT_CYCLES system clocks while a frame is partly received, the bit count returns to zero. The next complete frame then decodes correctly.
- R10: After reset the event strobe and the error pulse are low. Both are high for exactly one cycle at a time.
- R11: Prefix state is cleared when an event is issued, so the code after it is reported with both flags at 0 unless new prefixes arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| ps2ClkIn | input | 1 | Keyboard clock line, asynchronous |
| ps2DataIn | input | 1 | Keyboard data line, asynchronous |
| evValid | output | 1 | One-cycle key event strobe |
| evCode | output | 8 | Scan code of the event |
| evExtended | output | 1 | Event was preceded by the extended prefix |
| evRelease | output | 1 | Event is a key release |
| frameErr | output | 1 | One-cycle pulse for a rejected frame |

## Verification
The decoder is driven with plain make codes, release sequences, extended make and release sequences, and runs of the same code. These show whether the prefix flags are set, merged and cleared at the right byte, and whether repeats get through. Frames with bad parity or a zero stop bit are inserted between a prefix and a code. This shows that a rejected frame both raises the error and wipes the pending prefix. A truncated frame followed by a long idle gap tells apart a receiver that recovers through its watchdog from one that stays misaligned. The strobe cycle is checked against the falling edge of the stop bit, so the synchronizer depth is pinned as well.

// File: rtl/ps2kbd_pkg.sv
package ps2kbd_pkg;
  localparam int BYTE_W  = 8;
  localparam int FRAME_W = BYTE_W + 3;
  localparam logic [BYTE_W-1:0] CODE_BREAK = 8'hF0;
  localparam logic [BYTE_W-1:0] CODE_EXT   = 8'hE0;

  typedef struct packed {
    logic sample;   // take the current data bit
    logic finish;   // the bit taken now completes a frame
  } ctlStrobes_t;
endpackage

// File: rtl/ps2kbd_sync.sv
module ps2kbd_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic chain [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) chain[i] <= RESET_VAL;
        else       chain[i] <= asyncIn;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) chain[i] <= RESET_VAL;
        else       chain[i] <= chain[i-1];
      end
    end
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/ps2kbd_control.sv
module ps2kbd_control
  import ps2kbd_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 100000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        clkFall,
  output ctlStrobes_t strobes
);
  localparam int CNT_W  = $clog2(FRAME_W);
  localparam int IDLE_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(FRAME_W - 1);
  localparam logic [IDLE_W-1:0] IDLE_MAX = IDLE_W'(TIMEOUT_CYCLES - 1);

  logic [CNT_W-1:0]  bitCnt;
  logic [IDLE_W-1:0] idleCnt;
  logic              lastBit;
  logic              idleExpired;

  assign lastBit     = (bitCnt == LAST_BIT);
  assign idleExpired = (idleCnt == IDLE_MAX);

  always_comb begin
    strobes.sample = clkFall;
    strobes.finish = clkFall && lastBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt  <= '0;
      idleCnt <= '0;
    end else if (clkFall) begin
      idleCnt <= '0;
      bitCnt  <= lastBit ? '0 : bitCnt + 1'b1;
    end else if (bitCnt != '0) begin
      if (idleExpired) begin
        bitCnt  <= '0;
        idleCnt <= '0;
      end else begin
        idleCnt <= idleCnt + 1'b1;
      end
    end else begin
      idleCnt <= '0;
    end
  end

  AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= LAST_BIT); // R1
  AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (bitCnt != '0 && idleExpired && !clkFall) |=> (bitCnt == '0)); // R9
endmodule

// File: rtl/ps2kbd_datapath.sv
module ps2kbd_datapath
  import ps2kbd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ps2ClkIn,
  input  logic              ps2DataIn,
  input  ctlStrobes_t       strobes,
  output logic              clkFall,
  output logic              evValid,
  output logic [BYTE_W-1:0] evCode,
  output logic              evExtended,
  output logic              evRelease,
  output logic              frameErr
);
  logic clkS, dataS, clkPrev;
  logic [FRAME_W-2:0] shiftReg;
  logic [FRAME_W-1:0] frameVec;
  logic [BYTE_W-1:0]  byteVal;
  logic frameOk;
  logic relPend, extPend;

  ps2kbd_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) clkSync_i (
    .clk(clk), .rstN(rstN), .asyncIn(ps2ClkIn), .syncOut(clkS));
  ps2kbd_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) dataSync_i (
    .clk(clk), .rstN(rstN), .asyncIn(ps2DataIn), .syncOut(dataS));

  always_ff @(posedge clk) begin
    if (!rstN) clkPrev <= 1'b1;
    else       clkPrev <= clkS;
  end
  assign clkFall = clkPrev && !clkS;

  always_ff @(posedge clk) begin
    if (!rstN)               shiftReg <= '1;
    else if (strobes.sample) shiftReg <= {dataS, shiftReg[FRAME_W-2:1]};
  end

  assign frameVec = {dataS, shiftReg};
  assign byteVal  = frameVec[BYTE_W:1];
  assign frameOk  = !frameVec[0] && frameVec[FRAME_W-1] && (^frameVec[FRAME_W-2:1]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evValid    <= 1'b0;
      evCode     <= '0;
      evExtended <= 1'b0;
      evRelease  <= 1'b0;
      frameErr   <= 1'b0;
      relPend    <= 1'b0;
      extPend    <= 1'b0;
    end else begin
      evValid  <= 1'b0;
      frameErr <= 1'b0;
      if (strobes.finish) begin
        if (!frameOk) begin
          frameErr <= 1'b1;
          relPend  <= 1'b0;
          extPend  <= 1'b0;
        end else if (byteVal == CODE_BREAK) begin
          relPend <= 1'b1;
        end else if (byteVal == CODE_EXT) begin
          extPend <= 1'b1;
        end else begin
          evValid    <= 1'b1;
          evCode     <= byteVal;
          evExtended <= extPend;
          evRelease  <= relPend;
          relPend    <= 1'b0;
          extPend    <= 1'b0;
        end
      end
    end
  end

  AST_EVT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    evValid |=> !evValid); // R10
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |=> !frameErr); // R10
  AST_EVT_ERR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(evValid && frameErr)); // R7
  AST_ERR_CLEARS_PREFIX: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |-> (!relPend && !extPend)); // R7
  AST_EVT_CLEARS_PREFIX: assert property (@(posedge clk) disable iff (!rstN)
    evValid |-> (!relPend && !extPend)); // R11
endmodule

// File: rtl/ps2kbd_decoder.sv
module ps2kbd_decoder
  import ps2kbd_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 100000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ps2ClkIn,
  input  logic       ps2DataIn,
  output logic       evValid,
  output logic [7:0] evCode,
  output logic       evExtended,
  output logic       evRelease,
  output logic       frameErr
);
  ctlStrobes_t strobes;
  logic        clkFall;

  ps2kbd_datapath #(.SYNC_STAGES(SYNC_STAGES)) datapath_i (
    .clk(clk), .rstN(rstN), .ps2ClkIn(ps2ClkIn), .ps2DataIn(ps2DataIn),
    .strobes(strobes), .clkFall(clkFall), .evValid(evValid), .evCode(evCode),
    .evExtended(evExtended), .evRelease(evRelease), .frameErr(frameErr));

  ps2kbd_control #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) control_i (
    .clk(clk), .rstN(rstN), .clkFall(clkFall), .strobes(strobes));
endmodule

// File: tb/ps2kbd_decoder_tb.sv
module ps2kbd_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TIMEOUT    = 200;
  localparam int HALF_BIT   = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ps2Clk = 1'b1;
  logic ps2Data = 1'b1;
  logic evValid, evExtended, evRelease, frameErr;
  logic [7:0] evCode;

  int checks = 0;
  int errors = 0;
  logic [9:0] expQ[$];
  int errPend = 0;
  bit mRel = 0;
  bit mExt = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ps2kbd_decoder #(.TIMEOUT_CYCLES(TIMEOUT), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rstN(rstN), .ps2ClkIn(ps2Clk), .ps2DataIn(ps2Data),
    .evValid(evValid), .evCode(evCode), .evExtended(evExtended),
    .evRelease(evRelease), .frameErr(frameErr));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // reference comparison on every clock
  always @(negedge clk) begin
    if (rstN) begin
      if (evValid) begin
        if (expQ.size() == 0) begin
          check(0, "R6", "unexpected event", {evExtended, evRelease, evCode}, 0);
        end else begin
          logic [9:0] e;
          e = expQ.pop_front();
          check({evExtended, evRelease, evCode} == e, "R3/R4/R5/R11",
                "event {ext,rel,code}", {evExtended, evRelease, evCode}, e);
        end
      end
      if (frameErr) begin
        check(errPend > 0, "R7/R8", "unexpected error pulse", 1, 0);
        if (errPend > 0) errPend--;
      end
    end
  end

  task automatic sendFrame(input logic [7:0] b, input bit badPar, input bit badStop,
                           input int nBits);
    logic [10:0] bits;
    bit expEv, expErr;
    bits = {~badStop, (~^b) ^ badPar, b, 1'b0};  // R1 bit order
    expEv = 0; expErr = 0;
    if (nBits == 11) begin
      if (badPar || badStop) begin
        expErr = 1; errPend++; mRel = 0; mExt = 0;
      end else if (b == 8'hF0) mRel = 1;
      else if (b == 8'hE0) mExt = 1;
      else begin
        expEv = 1; expQ.push_back({mExt, mRel, b}); mRel = 0; mExt = 0;
      end
    end
    for (int i = 0; i < nBits; i++) begin
      @(negedge clk); ps2Data = bits[i];
      repeat (HALF_BIT/2) @(negedge clk);
      ps2Clk = 1'b0;
      if (i == 10) begin
        repeat (2) @(negedge clk);
        check(!evValid && !frameErr, "R2", "strobe too early", {evValid, frameErr}, 0);
        @(negedge clk);
        check(evValid == expEv && frameErr == expErr, "R2", "strobe at third edge",
              {evValid, frameErr}, {expEv, expErr});
        repeat (HALF_BIT - 3) @(negedge clk);
      end else begin
        repeat (HALF_BIT) @(negedge clk);
      end
      ps2Clk = 1'b1;
      repeat (HALF_BIT/2) @(negedge clk);
    end
    ps2Data = 1'b1;
    repeat (30) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R10", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    check(!evValid && !frameErr, "R10", "outputs in reset", {evValid, frameErr}, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(!evValid && !frameErr && evCode == 8'h00, "R10", "reset state",
          {evValid, frameErr, evCode}, 0);
    // R1 R3 plain make codes, incl. extreme byte values
    sendFrame(8'h1C, 0, 0, 11);
    sendFrame(8'h00, 0, 0, 11);
    sendFrame(8'hFF, 0, 0, 11);
    sendFrame(8'h81, 0, 0, 11);
    // R4 release
    sendFrame(8'hF0, 0, 0, 11);
    sendFrame(8'h1C, 0, 0, 11);
    // R5 extended make and extended release
    sendFrame(8'hE0, 0, 0, 11);
    sendFrame(8'h75, 0, 0, 11);
    sendFrame(8'hE0, 0, 0, 11);
    sendFrame(8'hF0, 0, 0, 11);
    sendFrame(8'h75, 0, 0, 11);
    // R11 code after an event carries no flags
    sendFrame(8'h29, 0, 0, 11);
    // R6 repeats
    for (int k = 0; k < 3; k++) sendFrame(8'h23, 0, 0, 11);
    // R7 parity error wipes release prefix
    sendFrame(8'hF0, 0, 0, 11);
    sendFrame(8'h44, 1, 0, 11);
    sendFrame(8'h4D, 0, 0, 11);
    // R8 stop-bit error wipes extended prefix
    sendFrame(8'hE0, 0, 0, 11);
    sendFrame(8'h6B, 0, 1, 11);
    sendFrame(8'h74, 0, 0, 11);
    // R9 partial frame then idle longer than the timeout
    sendFrame(8'h55, 0, 0, 5);
    repeat (TIMEOUT * 2) @(negedge clk);
    sendFrame(8'h2D, 0, 0, 11);
    sendFrame(8'hE0, 0, 0, 11);
    sendFrame(8'h14, 0, 0, 11);
    repeat (20) @(negedge clk);
    check(expQ.size() == 0, "R6", "events left unseen", expQ.size(), 0);
    check(errPend == 0, "R7", "error pulses left unseen", errPend, 0);
    summary();
  end
endmodule